// File: doc/BRIEF.md
# Parallel Memory Bootstrap Program Loader

This block copies a program image from an external parallel non-volatile memory into on-chip program RAM after reset. It then reports the address at which the loaded code should begin running. A single-cycle start pulse launches it. It reads from a fixed base address in the external memory through a simple synchronous read port. The port is either 24 bits wide, or 8 bits wide with three bytes joined into each 24-bit word, most significant byte first.

The image carries a header and a payload. The header holds two words: how many program words follow, and the program RAM address where they go. Each payload word is written to the next program RAM location, one write-enable cycle per word. When the last word has been written, the block raises a one-cycle done pulse and presents the load address as the entry point. The core uses that address as its first fetch.

Top module: `pboot_loader`

## Requirements
- R1: While idle, a start pulse begins a load. Reading starts at external address 0x800000 (parameter BOOT_BASE), and busy_o is high from the next cycle until the load ends.
- R2: The first 24-bit word of the image is the number of payload words to copy.
- R3: The second 24-bit word is the load address. Its low PRAM_AW bits are the first program RAM address written.
- R4: Payload word k (counting from 0) is written to load address + k, wrapping modulo 2^PRAM_AW. pram_we_o is high for exactly one cycle per payload word and never for a header word.
- R5: When byte_mode_i is 1 at start, each word is built from three reads. Only mem_rdata_i[7:0] is used, and the first byte becomes bits 23:16, the second bits 15:8 and the third bits 7:0. When byte_mode_i is 0, each read is one full word.
- R6: mem_addr_o goes up by one after each read that returns mem_valid_i, in both modes. While mem_req_o is high and no valid has come back, mem_addr_o holds.
- R7: done_o is a single-cycle pulse. It comes in the same cycle as the last payload write, and busy_o is low in that cycle. entry_o then equals the load address and holds it until the next load.
- R8: A word count of zero causes no program RAM write. done_o rises on the cycle after the load-address word arrives.
- R9: A start pulse that arrives while busy_o is high has no effect on the load in progress.
- R10: After reset, mem_req_o, pram_we_o, done_o and busy_o are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Single-cycle launch pulse |
| byte_mode_i | input | 1 | 1 = 8-bit reads joined into words, 0 = 24-bit reads |
| mem_req_o | output | 1 | External read request, held until valid |
| mem_addr_o | output | EXT_AW | External read address |
| mem_rdata_i | input | WORD_W | External read data |
| mem_valid_i | input | 1 | External read data valid |
| pram_we_o | output | 1 | Program RAM write enable |
| pram_addr_o | output | PRAM_AW | Program RAM write address |
| pram_wdata_o | output | WORD_W | Program RAM write data |
| busy_o | output | 1 | Load in progress |
| done_o | output | 1 | Load complete pulse |
| entry_o | output | PRAM_AW | Entry address for the loaded code |

## Verification
The last payload write and the completion pulse fall in the same cycle. The bench therefore samples the cycle in which done_o is high and expects pram_we_o high, except for zero-length images, where it expects pram_we_o low. A second start pulse is also sent in the middle of a running load, in the same cycle as read traffic. The bench checks that the write stream and the external address sequence carry on without a break, comparing them with a model of the image and a count of the reads issued.

// File: rtl/pbl_pkg.sv
package pbl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LEN  = 2'd1,
    ST_ORG  = 2'd2,
    ST_PAY  = 2'd3
  } ld_state_e;
endpackage

// File: rtl/pbl_fetch.sv
module pbl_fetch #(
  parameter int unsigned         EXT_AW    = 24,
  parameter logic [EXT_AW-1:0]   BOOT_BASE = 24'h800000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch_i,
  input  logic              active_i,
  input  logic              mem_valid_i,
  output logic              mem_req_o,
  output logic [EXT_AW-1:0] mem_addr_o
);
  logic [EXT_AW-1:0] addr_q, addr_d;
  logic              addr_en;

  assign addr_en = launch_i | (active_i & mem_valid_i);

  always_comb begin
    addr_d = addr_q;
    if (launch_i)                     addr_d = BOOT_BASE;
    else if (active_i && mem_valid_i) addr_d = addr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= BOOT_BASE;
    else if (addr_en) addr_q <= addr_d;
  end

  assign mem_req_o  = active_i;
  assign mem_addr_o = addr_q;

  // R6: address held while a request waits
  a_r6_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_valid_i) |=> $stable(mem_addr_o));
  // R6: address steps by one on each returned read
  a_r6_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_valid_i) |=> (mem_addr_o == $past(mem_addr_o) + 1'b1));
endmodule

// File: rtl/pbl_word_asm.sv
module pbl_word_asm #(
  parameter int unsigned WORD_W = 24,
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              byte_mode_i,
  input  logic              valid_i,
  input  logic [WORD_W-1:0] rdata_i,
  output logic              word_vld_o,
  output logic [WORD_W-1:0] word_o
);
  localparam int unsigned NBYTES = WORD_W / BYTE_W;
  localparam int unsigned CNT_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1;
  localparam int unsigned ACC_W  = WORD_W - BYTE_W;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NBYTES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [ACC_W-1:0] acc_q, acc_d;
  logic             byte_last;

  assign byte_last = (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    acc_d = acc_q;
    if (clr_i) begin
      cnt_d = '0;
    end else if (valid_i && byte_mode_i) begin
      cnt_d = byte_last ? '0 : cnt_q + 1'b1;
      acc_d = {acc_q[ACC_W-BYTE_W-1:0], rdata_i[BYTE_W-1:0]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      acc_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      acc_q <= acc_d;
    end
  end

  assign word_vld_o = valid_i & (~byte_mode_i | byte_last);
  assign word_o     = byte_mode_i ? {acc_q, rdata_i[BYTE_W-1:0]} : rdata_i;

  // R5: byte position counter never leaves its range
  a_r5_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  // R5: a byte completing a word returns the counter to the first position
  a_r5_cnt_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && byte_mode_i && !clr_i && byte_last) |=> (cnt_q == '0));
endmodule

// File: rtl/pbl_ctrl.sv
module pbl_ctrl
  import pbl_pkg::*;
#(
  parameter int unsigned WORD_W  = 24,
  parameter int unsigned PRAM_AW = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               byte_mode_i,
  input  logic               word_vld_i,
  input  logic [WORD_W-1:0]  word_i,
  output logic               launch_o,
  output logic               active_o,
  output logic               mode_o,
  output logic               pram_we_o,
  output logic [PRAM_AW-1:0] pram_addr_o,
  output logic [WORD_W-1:0]  pram_wdata_o,
  output logic               done_o,
  output logic [PRAM_AW-1:0] entry_o
);
  ld_state_e          state_q, state_d;
  logic [WORD_W-1:0]  remain_q, remain_d;
  logic [PRAM_AW-1:0] ptr_q, ptr_d;
  logic [PRAM_AW-1:0] entry_q, entry_d;
  logic               mode_q, mode_d;
  logic               we_q, we_d;
  logic [PRAM_AW-1:0] waddr_q, waddr_d;
  logic [WORD_W-1:0]  wdata_q, wdata_d;
  logic               done_q, done_d;

  assign launch_o = start_i & (state_q == ST_IDLE);

  always_comb begin
    state_d  = state_q;
    remain_d = remain_q;
    ptr_d    = ptr_q;
    entry_d  = entry_q;
    mode_d   = mode_q;
    we_d     = 1'b0;
    waddr_d  = waddr_q;
    wdata_d  = wdata_q;
    done_d   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_LEN;
          mode_d  = byte_mode_i;
        end
      end
      ST_LEN: begin
        if (word_vld_i) begin
          remain_d = word_i;
          state_d  = ST_ORG;
        end
      end
      ST_ORG: begin
        if (word_vld_i) begin
          ptr_d   = word_i[PRAM_AW-1:0];
          entry_d = word_i[PRAM_AW-1:0];
          if (remain_q == '0) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end else begin
            state_d = ST_PAY;
          end
        end
      end
      ST_PAY: begin
        if (word_vld_i) begin
          we_d     = 1'b1;
          waddr_d  = ptr_q;
          wdata_d  = word_i;
          ptr_d    = ptr_q + 1'b1;
          remain_d = remain_q - 1'b1;
          if (remain_q == WORD_W'(1)) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      remain_q <= '0;
      ptr_q    <= '0;
      entry_q  <= '0;
      mode_q   <= 1'b0;
      we_q     <= 1'b0;
      waddr_q  <= '0;
      wdata_q  <= '0;
      done_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      remain_q <= remain_d;
      ptr_q    <= ptr_d;
      entry_q  <= entry_d;
      mode_q   <= mode_d;
      we_q     <= we_d;
      waddr_q  <= waddr_d;
      wdata_q  <= wdata_d;
      done_q   <= done_d;
    end
  end

  assign active_o     = (state_q != ST_IDLE);
  assign mode_o       = mode_q;
  assign pram_we_o    = we_q;
  assign pram_addr_o  = waddr_q;
  assign pram_wdata_o = wdata_q;
  assign done_o       = done_q;
  assign entry_o      = entry_q;

  // R4: writes come only from the payload phase
  a_r4_we_payload: assert property (@(posedge clk) disable iff (!rst_n)
    pram_we_o |-> $past(state_q == ST_PAY));
  // R7: done is a single-cycle pulse and the block is idle with it
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !active_o);
  // R8: a zero count ends the load right after the load-address word
  a_r8_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ORG && word_vld_i && remain_q == '0) |=> (done_o && !pram_we_o));
  // R9: a start pulse during a load does not disturb the phase
  a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && start_i && !word_vld_i) |=> $stable(state_q));
endmodule

// File: rtl/pboot_loader.sv
module pboot_loader #(
  parameter int unsigned       EXT_AW    = 24,
  parameter int unsigned       WORD_W    = 24,
  parameter int unsigned       BYTE_W    = 8,
  parameter int unsigned       PRAM_AW   = 16,
  parameter logic [EXT_AW-1:0] BOOT_BASE = 24'h800000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               byte_mode_i,
  output logic               mem_req_o,
  output logic [EXT_AW-1:0]  mem_addr_o,
  input  logic [WORD_W-1:0]  mem_rdata_i,
  input  logic               mem_valid_i,
  output logic               pram_we_o,
  output logic [PRAM_AW-1:0] pram_addr_o,
  output logic [WORD_W-1:0]  pram_wdata_o,
  output logic               busy_o,
  output logic               done_o,
  output logic [PRAM_AW-1:0] entry_o
);
  logic              launch, active, mode, word_vld, rd_vld;
  logic [WORD_W-1:0] word;

  assign rd_vld = mem_valid_i & active;

  pbl_fetch #(.EXT_AW(EXT_AW), .BOOT_BASE(BOOT_BASE)) u_fetch (
    .clk(clk), .rst_n(rst_n), .launch_i(launch), .active_i(active),
    .mem_valid_i(mem_valid_i), .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o)
  );

  pbl_word_asm #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_asm (
    .clk(clk), .rst_n(rst_n), .clr_i(launch), .byte_mode_i(mode),
    .valid_i(rd_vld), .rdata_i(mem_rdata_i),
    .word_vld_o(word_vld), .word_o(word)
  );

  pbl_ctrl #(.WORD_W(WORD_W), .PRAM_AW(PRAM_AW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .byte_mode_i(byte_mode_i),
    .word_vld_i(word_vld), .word_i(word), .launch_o(launch), .active_o(active),
    .mode_o(mode), .pram_we_o(pram_we_o), .pram_addr_o(pram_addr_o),
    .pram_wdata_o(pram_wdata_o), .done_o(done_o), .entry_o(entry_o)
  );

  assign busy_o = active;

  // R10: nothing is requested or written outside a load
  a_r10_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !mem_req_o);
  // R1: a start pulse while idle makes the block busy on the next cycle
  a_r1_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);
endmodule

// File: tb/sim_pboot_loader.sv
module sim_pboot_loader;
  localparam int CLK_PERIOD = 10;
  localparam logic [23:0] BASE = 24'h800000;
  localparam int IMG_N = 66;

  logic        clk, rst_n, start_i, byte_mode_i;
  logic        mem_req_o, mem_valid_i, pram_we_o, busy_o, done_o;
  logic [23:0] mem_addr_o, mem_rdata_i, pram_wdata_o;
  logic [15:0] pram_addr_o, entry_o;

  int errors = 0, checks = 0, cycles = 0;
  int issue_cnt = 0, issue_err = 0;
  logic [23:0] img [IMG_N];
  logic cur_byte, slow;

  pboot_loader u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .byte_mode_i(byte_mode_i),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_rdata_i(mem_rdata_i),
    .mem_valid_i(mem_valid_i), .pram_we_o(pram_we_o), .pram_addr_o(pram_addr_o),
    .pram_wdata_o(pram_wdata_o), .busy_o(busy_o), .done_o(done_o), .entry_o(entry_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      $display("FAIL watchdog: actual=%0d cycles expected<150000", cycles);
      errors++; checks++;
      finish_run();
    end
  end

  // R6/R5 memory model: one-cycle latency, optional random wait
  function automatic logic [23:0] mem_value(logic [23:0] a, logic bm);
    int idx = int'(a - BASE);
    logic [23:0] w;
    if (!bm) return (idx < IMG_N) ? img[idx] : 24'hDEAD00;
    w = (idx / 3 < IMG_N) ? img[idx / 3] : 24'h0;
    return {16'($urandom()), 8'(w >> (16 - 8 * (idx % 3)))};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_valid_i <= 1'b0;
      mem_rdata_i <= '0;
    end else if (mem_req_o && !mem_valid_i && (!slow || $urandom_range(0, 2) == 0)) begin
      if (mem_addr_o != BASE + 24'(issue_cnt)) issue_err++;
      issue_cnt++;
      mem_valid_i <= 1'b1;
      mem_rdata_i <= mem_value(mem_addr_o, cur_byte);
    end else begin
      mem_valid_i <= 1'b0;
    end
  end

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_load(bit bm, int n, logic [23:0] load, bit sl, int restart_at);
    int wr = 0, data_err = 0, guard = 0;
    logic [15:0] ld16 = load[15:0];
    cur_byte = bm; slow = sl;
    img[0] = 24'(n); img[1] = load;
    for (int i = 2; i < IMG_N; i++) img[i] = 24'($urandom());
    issue_cnt = 0; issue_err = 0;
    @(negedge clk);
    byte_mode_i = bm; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; byte_mode_i = ~bm;
    chk(busy_o == 1'b1, "R1 busy after start", busy_o, 1);
    forever begin
      if (pram_we_o) begin
        if (pram_addr_o != ld16 + 16'(wr) || pram_wdata_o != img[2 + wr]) begin
          data_err++;
          $display("  write %0d: addr=%0h data=%0h", wr, pram_addr_o, pram_wdata_o);
        end
        wr++;
      end
      if (done_o) break;
      guard++;
      if (guard > 4000) break;
      start_i = (guard == restart_at);
      @(negedge clk);
    end
    start_i = 1'b0;
    chk(done_o == 1'b1, "R7 done reached", done_o, 1);
    chk(busy_o == 1'b0, "R7 busy low with done", busy_o, 0);
    chk(pram_we_o == (n != 0), "R7 last write with done", pram_we_o, n != 0);
    chk(entry_o == ld16, "R3/R7 entry address", entry_o, ld16);
    if (n == 0) chk(wr == 0, "R8 zero count writes", wr, 0);
    else chk(wr == n, "R2/R4 write count", wr, n);
    chk(data_err == 0, bm ? "R5 byte-mode write data/addr" : "R4 word-mode write data/addr", data_err, 0);
    chk(issue_err == 0, "R6 external address sequence", issue_err, 0);
    chk(issue_cnt >= (bm ? 3 : 1) * (n + 2), "R6 read count", issue_cnt, (bm ? 3 : 1) * (n + 2));
    if (restart_at > 0) chk(wr == n && data_err == 0, "R9 restart ignored", wr, n);
    @(negedge clk);
    chk(done_o == 1'b0, "R7 done single cycle", done_o, 0);
    chk(entry_o == ld16, "R7 entry holds", entry_o, ld16);
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0; start_i = 1'b0; byte_mode_i = 1'b0; cur_byte = 1'b0; slow = 1'b0;
    for (int i = 0; i < IMG_N; i++) img[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!mem_req_o && !pram_we_o && !done_o && !busy_o, "R10 reset state",
        {mem_req_o, pram_we_o, done_o, busy_o}, 0);
    chk(mem_addr_o == BASE, "R1 base address", mem_addr_o, BASE);
    // directed corners
    run_load(1'b0, 4, 24'h000100, 1'b0, 0);
    run_load(1'b1, 4, 24'h000200, 1'b0, 0);
    run_load(1'b0, 0, 24'h001234, 1'b0, 0);
    run_load(1'b1, 0, 24'h004321, 1'b1, 0);
    run_load(1'b0, 1, 24'h00FFFF, 1'b1, 0);
    run_load(1'b1, 3, 24'h12FFFE, 1'b0, 0);
    run_load(1'b0, 10, 24'h000400, 1'b1, 7);
    run_load(1'b1, 8, 24'h000500, 1'b0, 11);
    // constrained random
    for (int t = 0; t < 16; t++) begin
      run_load(1'($urandom()), $urandom_range(0, 40), 24'($urandom()),
               1'($urandom()), (t % 3 == 0) ? $urandom_range(1, 20) : 0);
    end
    finish_run();
  end
endmodule